// File: doc/BRIEF.md
# Descriptor Ring Batch Doorbell Engine

This block sits between descriptor-building logic and a hardware queue manager. Descriptors are already present in a circular ring in memory. The producer asks the block to submit N of them. The block cuts that request into batches of at most 255 descriptors. For each batch it does two things in order: it marks the final descriptor of the batch with a last-in-batch flag write, and then it writes one 32-bit doorbell word to the queue manager. The doorbell word carries the batch length, a descriptor size code and the 64-byte-granular address of the batch's first descriptor.

The block owns the ring's head pointer, which it advances by each batch. It follows a tail pointer that the consumer moves with an advance strobe. It counts batches that have been rung but not yet reported complete. From head, tail and ring depth it continuously reports the slots still free for enqueue and the entries waiting to be dequeued. The ring depth is selected at run time as a power of two.

Top module: `ring_doorbell`

## Requirements
- R1: A request with a nonzero count, seen while `busy` is low, is accepted. `busy` rises on the next cycle and falls in the cycle after the final doorbell of that request. A request arriving while `busy` is high has no effect. So does a request with a count of zero.
- R2: A count of N is issued as successive batches of min(remaining, 255) descriptors until N is used up. For example, 600 becomes 255, 255 and 90.
- R3: Each doorbell word holds the batch count in bits [7:0], the size code 4 (256-byte descriptors / 64) in bits [10:8], and zero in bit 11.
- R4: Doorbell bits [31:12] hold bits [25:6] of base + (head AND mask) × 256, where head is the head pointer before that batch.
- R5: For each batch, `flag_we` pulses for one cycle with `flag_idx` = (head + batch − 1) AND mask. `db_we` pulses in the very next cycle. The two strobes never coincide.
- R6: After each doorbell the head advances by the batch size. The in-flight batch count rises by one per doorbell and falls by one per `batch_done`. A doorbell and a `batch_done` in the same cycle leave it unchanged. A `batch_done` at zero is ignored.
- R7: `free_slots` = (depth − 1 + tail − head) AND mask and `pending` = (depth + head − tail) AND mask. `tail_adv` adds `tail_num` to the tail.
- R8: depth = 2^`depth_log2` and mask = depth − 1. Values of `depth_log2` above 10 act as 10, so the depth is at most 1024.
- R9: After reset, head, tail and the in-flight count are zero, both strobes are low, `busy` is low, `pending` is 0 and `free_slots` equals the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of ring slot 0 |
| depth_log2 | input | 4 | log2 of ring depth (clamped to 10) |
| req_valid | input | 1 | Submit request strobe |
| req_count | input | 16 | Number of descriptors to submit |
| busy | output | 1 | A request is being issued |
| tail_adv | input | 1 | Tail advance strobe |
| tail_num | input | 11 | Amount added to tail on `tail_adv` |
| batch_done | input | 1 | One batch completed by the consumer |
| flag_we | output | 1 | Last-in-batch flag write strobe |
| flag_idx | output | 10 | Ring index receiving the flag |
| db_we | output | 1 | Doorbell write strobe |
| db_data | output | 32 | Doorbell word |
| free_slots | output | 10 | Slots free for enqueue |
| pending | output | 10 | Entries awaiting dequeue |
| inflight | output | 16 | Batches rung and not yet completed |

## Verification
The doorbell cycle, which advances the head and raises the in-flight count, can coincide with both consumer strobes: a tail advance and a batch completion. The bench drives `tail_adv` and `batch_done` during the cycle in which `db_we` is high. It then checks that the in-flight count is unchanged, and that `free_slots` and `pending` reflect both the new head and the new tail on the following cycle. A second overlap, a request arriving during the flag cycle of an active request, is checked by confirming that no further flag or doorbell appears and that `pending` matches only the first request.

// File: rtl/ring_doorbell.sv
module ring_doorbell #(
  parameter int MAX_DEPTH  = 1024,
  parameter int DESC_BYTES = 256,
  parameter int BATCH_MAX  = 255,
  parameter int REQ_W      = 16,
  parameter int FLIGHT_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [31:0]                  ring_base,
  input  logic [3:0]                   depth_log2,
  input  logic                         req_valid,
  input  logic [REQ_W-1:0]             req_count,
  output logic                         busy,
  input  logic                         tail_adv,
  input  logic [$clog2(MAX_DEPTH):0]   tail_num,
  input  logic                         batch_done,
  output logic                         flag_we,
  output logic [$clog2(MAX_DEPTH)-1:0] flag_idx,
  output logic                         db_we,
  output logic [31:0]                  db_data,
  output logic [$clog2(MAX_DEPTH)-1:0] free_slots,
  output logic [$clog2(MAX_DEPTH)-1:0] pending,
  output logic [FLIGHT_W-1:0]          inflight
);
  localparam int LG_MAX    = $clog2(MAX_DEPTH);
  localparam int PW        = LG_MAX + 1;
  localparam int SIZE_CODE = DESC_BYTES / 64;
  localparam int DESC_SH   = $clog2(DESC_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_FLAG, S_DB} st_t;
  st_t st;

  logic [PW-1:0]    head, tail;
  logic [REQ_W-1:0] rem;

  logic [3:0]    lg_eff;
  logic [PW-1:0] depth, mask, slot;
  logic [7:0]    bs;
  logic [31:0]   addr;

  assign lg_eff = (depth_log2 > 4'(LG_MAX)) ? 4'(LG_MAX) : depth_log2;
  assign depth  = PW'(1) << lg_eff;
  assign mask   = depth - PW'(1);
  assign bs     = (rem > REQ_W'(BATCH_MAX)) ? 8'(BATCH_MAX) : rem[7:0];
  assign slot   = head & mask;
  assign addr   = ring_base + (32'(slot) << DESC_SH);

  assign busy     = (st != S_IDLE);
  assign flag_we  = (st == S_FLAG);
  assign db_we    = (st == S_DB);
  assign flag_idx = LG_MAX'((head + PW'(bs) - PW'(1)) & mask);
  assign db_data  = {addr[25:6], 1'b0, 3'(SIZE_CODE), bs};

  assign free_slots = LG_MAX'((depth - PW'(1) + tail - head) & mask);
  assign pending    = LG_MAX'((depth + head - tail) & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      head <= '0;
      rem  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && req_count != '0) begin
          rem <= req_count;
          st  <= S_FLAG;
        end
        S_FLAG: st <= S_DB;
        S_DB: begin
          head <= head + PW'(bs);
          rem  <= rem - REQ_W'(bs);
          st   <= (rem == REQ_W'(bs)) ? S_IDLE : S_FLAG;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        tail <= '0;
    else if (tail_adv) tail <= tail + tail_num;
  end

  logic inc, dec;
  assign inc = (st == S_DB);
  assign dec = batch_done && (inflight != '0 || inc);

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else case ({inc, dec})
      2'b10:   inflight <= inflight + FLIGHT_W'(1);
      2'b01:   inflight <= inflight - FLIGHT_W'(1);
      default: inflight <= inflight;
    endcase
  end
endmodule

module ring_doorbell_chk #(
  parameter int LG_MAX    = 10,
  parameter int REQ_W     = 16,
  parameter int FLIGHT_W  = 16,
  parameter int SIZE_CODE = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [3:0]          depth_log2,
  input logic                req_valid,
  input logic [REQ_W-1:0]    req_count,
  input logic                busy,
  input logic                batch_done,
  input logic                flag_we,
  input logic                db_we,
  input logic [31:0]         db_data,
  input logic [LG_MAX-1:0]   free_slots,
  input logic [LG_MAX-1:0]   pending,
  input logic [FLIGHT_W-1:0] inflight
);
  logic [3:0]  lg_c;
  logic [31:0] mask_c;
  assign lg_c   = (depth_log2 > 4'(LG_MAX)) ? 4'(LG_MAX) : depth_log2;
  assign mask_c = (32'd1 << lg_c) - 32'd1;

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_count != '0) |=> (busy && flag_we));
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_valid && req_count != '0)) |=> !busy);
  assert_db_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    db_we |-> (db_data[7:0] != 8'd0 && !db_data[11] && db_data[10:8] == 3'(SIZE_CODE)));
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_we && db_we));
  assert_flag_then_db_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> db_we);
  assert_db_after_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    db_we |-> $past(flag_we));
  assert_inflight_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (db_we && !batch_done) |=> inflight == $past(inflight) + FLIGHT_W'(1));
  assert_inflight_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (db_we && batch_done) |=> $stable(inflight));
  assert_counts_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_slots) + 32'(pending) == mask_c);
  assert_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pending) <= mask_c);
endmodule

bind ring_doorbell ring_doorbell_chk #(
  .LG_MAX(LG_MAX), .REQ_W(REQ_W), .FLIGHT_W(FLIGHT_W), .SIZE_CODE(SIZE_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .depth_log2(depth_log2), .req_valid(req_valid),
  .req_count(req_count), .busy(busy), .batch_done(batch_done),
  .flag_we(flag_we), .db_we(db_we), .db_data(db_data),
  .free_slots(free_slots), .pending(pending), .inflight(inflight)
);

// File: tb/ring_doorbell_test.sv
`timescale 1ns/1ps
module ring_doorbell_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ring_base = 32'h0001_0000;
  logic [3:0]  depth_log2 = 4'd4;
  logic        req_valid = 0;
  logic [15:0] req_count = 0;
  logic        tail_adv = 0;
  logic [10:0] tail_num = 0;
  logic        batch_done = 0;
  logic        busy, flag_we, db_we;
  logic [9:0]  flag_idx, free_slots, pending;
  logic [31:0] db_data;
  logic [15:0] inflight;

  always #2 clk = ~clk;

  ring_doorbell uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .depth_log2(depth_log2),
    .req_valid(req_valid), .req_count(req_count), .busy(busy),
    .tail_adv(tail_adv), .tail_num(tail_num), .batch_done(batch_done),
    .flag_we(flag_we), .flag_idx(flag_idx), .db_we(db_we), .db_data(db_data),
    .free_slots(free_slots), .pending(pending), .inflight(inflight)
  );

  int errors = 0, checks = 0;
  int head_m = 0, tail_m = 0, infl_m = 0;

  localparam int NV = 4;
  localparam int V_LG[NV]   = '{4, 6, 10, 3};
  localparam int V_BASE[NV] = '{32'h0001_0000, 32'h0040_0040, 32'h1000_0000, 32'h0ABC_0000};
  localparam int V_N[NV]    = '{5, 40, 600, 20};
  localparam int V_TAIL[NV] = '{5, 20, 600, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mask_of(input int lg);
    return (1 << ((lg > 10) ? 10 : lg)) - 1;
  endfunction

  task automatic check_counts(input string req);
    int m = mask_of(int'(depth_log2));
    int ef = (m + tail_m - head_m) & m;
    int ep = (m + 1 + head_m - tail_m) & m;
    check(int'(free_slots) == ef, req, int'(free_slots), ef);
    check(int'(pending) == ep, req, int'(pending), ep);
  endtask

  task automatic run_req(input int n, input bit conc, input int tstep, input bit intr);
    int rem = n;
    bit first = 1;
    req_valid = 1; req_count = 16'(n);
    @(posedge clk); #1 req_valid = 0;
    check(busy == 1, "R1 busy after accept", int'(busy), 1);
    while (rem > 0) begin
      int bs = (rem > 255) ? 255 : rem;
      int m = mask_of(int'(depth_log2));
      int addr = int'(ring_base) + ((head_m & m) * 256);
      int eidx = (head_m + bs - 1) & m;
      check(flag_we == 1 && db_we == 0, "R5 flag strobe", int'(flag_we), 1);
      check(int'(flag_idx) == eidx, "R5 flag index", int'(flag_idx), eidx);
      if (first && intr) begin req_valid = 1; req_count = 16'd7; end
      @(posedge clk); #1;
      req_valid = 0;
      first = 0;
      check(db_we == 1 && flag_we == 0, "R5 doorbell follows flag", int'(db_we), 1);
      check(int'(db_data[7:0]) == bs, "R2 batch count", int'(db_data[7:0]), bs);
      check(db_data[10:8] == 3'd4 && db_data[11] == 1'b0, "R3 size code and reserved",
            int'(db_data[11:8]), 4);
      check(int'(db_data[31:12]) == ((addr >> 6) & 32'hFFFFF), "R4 address field",
            int'(db_data[31:12]), (addr >> 6) & 32'hFFFFF);
      if (conc && rem <= 255) begin
        tail_adv = 1; tail_num = 11'(tstep); batch_done = 1;
      end
      @(posedge clk); #1;
      if (tail_adv) begin tail_m += tstep; infl_m -= 1; end
      tail_adv = 0; batch_done = 0;
      head_m += bs; rem -= bs; infl_m += 1;
      check(int'(inflight) == infl_m, "R6 in-flight count", int'(inflight), infl_m);
    end
    check(busy == 0, "R1 busy falls after last doorbell", int'(busy), 0);
    check_counts("R7 counts after request");
  endtask

  task automatic adv_tail(input int k);
    tail_adv = 1; tail_num = 11'(k);
    @(posedge clk); #1 tail_adv = 0;
    tail_m += k;
    check_counts("R7 counts after tail advance");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R9 reset state
    check(busy == 0 && flag_we == 0 && db_we == 0, "R9 strobes and busy idle", int'(busy), 0);
    check(inflight == 0, "R9 in-flight zero", int'(inflight), 0);
    check(pending == 0 && free_slots == 10'd15, "R9 free equals mask", int'(free_slots), 15);

    // vector table
    for (int i = 0; i < NV; i++) begin
      depth_log2 = 4'(V_LG[i]);
      ring_base  = V_BASE[i];
      #1;
      run_req(V_N[i], 0, 0, 0);
      if (V_TAIL[i] != 0) adv_tail(V_TAIL[i]);
    end

    // R6/R7: doorbell coinciding with tail advance and batch completion
    depth_log2 = 4'd8; #1;
    run_req(30, 1, 12, 0);

    // R1: request during an active multi-batch request is ignored
    depth_log2 = 4'd10; #1;
    run_req(300, 0, 0, 1);
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      check(flag_we == 0 && busy == 0, "R1 refused request issues nothing", int'(flag_we), 0);
    end
    check_counts("R1 pending reflects first request only");

    // R1: zero-count request is ignored
    req_valid = 1; req_count = 0;
    @(posedge clk); #1 req_valid = 0;
    check(busy == 0 && flag_we == 0, "R1 zero-count request ignored", int'(busy), 0);

    // R8: clamp above 10 and a small depth
    depth_log2 = 4'd15; #1;
    check_counts("R8 depth_log2 above 10 acts as 10");
    depth_log2 = 4'd2; #1;
    check_counts("R8 depth 4 mask");

    // R6: drain and floor at zero
    while (infl_m > 0) begin
      batch_done = 1; @(posedge clk); #1 batch_done = 0; infl_m--;
    end
    check(int'(inflight) == 0, "R6 drained", int'(inflight), 0);
    batch_done = 1; @(posedge clk); #1 batch_done = 0;
    check(int'(inflight) == 0, "R6 completion at zero ignored", int'(inflight), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule